// File: doc/BRIEF.md
# Strobe-Handshake FIFO with Occupancy Flags

This block is a first-in first-out buffer of 64 words of 9 bits. A producer loads it with a two-phase strobe. It raises `shift_in` while `in_rdy` is high, and the word on `din` is taken at that rising edge. The producer then drops the strobe, and only after that drop can `in_rdy` return high. The consumer unloads it the same way with `shift_out` and `out_rdy`. The word on `dout` is the one consumed at the rising edge, and the next word is presented after the strobe falls.

Storage is a dual-port array addressed by a write pointer and a read pointer. Stored words are never moved. A 7-bit count tracks occupancy from 0 through 64. Two registered flags summarise it:
- a single edge-zone flag covers both the nearly-empty and the nearly-full ranges;
- a half flag shows the upper half.

Both flags move only in response to a strobe falling. Everything runs on one clock: the strobes are sampled, and their edges are found inside the block.

Top module: `strobe_fifo`

## Requirements
- R1: A synchronous reset empties the buffer. After it, `in_rdy`=1, `out_rdy`=0, `dout`=0, `flag_edge`=1 and `flag_half`=0.
- R2: A rising edge of `shift_in` seen while `in_rdy` is high stores `din`, and `in_rdy` is low from the next cycle.
- R3: After the falling edge of `shift_in`, `in_rdy` returns high one cycle later unless 64 words are stored. With 64 words stored it stays low.
- R4: A `shift_in` pulse while `in_rdy` is low stores nothing.
- R5: While the buffer is empty, `out_rdy` stays low, and `shift_out` pulses change neither the count nor `dout`.
- R6: One cycle after the `shift_in` fall that makes the count non-zero, `out_rdy` is high and `dout` shows the oldest word.
- R7: A rising edge of `shift_out` while `out_rdy` is high consumes the word, and `out_rdy` is low from the next cycle. One cycle after `shift_out` falls, `out_rdy` is high again with the next word if any word remains.
- R8: Words leave in the order they were stored.
- R9: `flag_edge` is 1 when the count is 8 or less, or 56 or more, and 0 for counts 9 through 55.
- R10: `flag_half` is 1 when the count is 32 or more, and 0 otherwise.
- R11: The flags change only in the cycle after a falling edge of `shift_in` or `shift_out`.
- R12: A load and an unload whose strobes fall in the same cycle leave the count unchanged and advance both pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| shift_in | input | 1 | Load strobe |
| din | input | 9 | Word to load |
| in_rdy | output | 1 | A free location is available |
| shift_out | input | 1 | Unload strobe |
| dout | output | 9 | Oldest stored word |
| out_rdy | output | 1 | A word is available on `dout` |
| flag_edge | output | 1 | Count is at most 8 or at least 56 |
| flag_half | output | 1 | Count is at least 32 |

## Verification
Each strobe edge is seen at the clock edge where the sampled strobe first differs from its previous value. The ready output it affects has changed by the next cycle.
- A rising strobe makes its ready output low one cycle after the edge.
- A falling strobe updates the count, the flags, `dout` and both ready outputs one cycle after that falling edge.

The bench drives every input on the falling clock edge. It samples one half-period later, right after the rising edge that registers the effect. The count, flags and ready outputs are therefore compared exactly one cycle after each strobe transition.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } strobe_ev_t;
endpackage

// File: rtl/sfifo_strobe.sv
module sfifo_strobe
  import sfifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe,
  output strobe_ev_t ev
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= strobe;
  end

  always_comb begin
    ev.rise = strobe & ~prev_q;
    ev.fall = ~strobe & prev_q;
  end
endmodule

// File: rtl/sfifo_ram.sv
module sfifo_ram #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags #(
  parameter int DEPTH    = 64,
  parameter int LOW_MAX  = 8,
  parameter int HIGH_MIN = 56,
  parameter int HALF_MIN = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count_n,
  output logic          flag_edge,
  output logic          flag_half
);
  localparam logic [CW-1:0] LoLim   = CW'(LOW_MAX);
  localparam logic [CW-1:0] HiLim   = CW'(HIGH_MIN);
  localparam logic [CW-1:0] HalfLim = CW'(HALF_MIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_edge <= 1'b1;
      flag_half <= 1'b0;
    end else begin
      flag_edge <= (count_n <= LoLim) || (count_n >= HiLim);
      flag_half <= (count_n >= HalfLim);
    end
  end
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
  parameter int WIDTH    = 9,
  parameter int DEPTH    = 64,
  parameter int EDGE_GAP = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             in_rdy,
  input  logic             shift_out,
  output logic [WIDTH-1:0] dout,
  output logic             out_rdy,
  output logic             flag_edge,
  output logic             flag_half
);
  import sfifo_pkg::*;

  localparam logic [CW-1:0] FullCnt = CW'(DEPTH);
  localparam logic [CW-1:0] One     = CW'(1);

  strobe_ev_t si_ev, so_ev;
  logic [AW-1:0] wptr_q, rptr_q, rptr_n;
  logic [CW-1:0] count_q, count_n;
  logic in_busy_q, out_busy_q, in_busy_n, out_busy_n;
  logic in_rdy_q, out_rdy_q;
  logic take_in, take_out, commit_in, commit_out;

  sfifo_strobe u_si (.clk(clk), .rst(rst), .strobe(shift_in),  .ev(si_ev));
  sfifo_strobe u_so (.clk(clk), .rst(rst), .strobe(shift_out), .ev(so_ev));

  // Strobe accept and commit decisions.
  always_comb begin
    take_in    = si_ev.rise && in_rdy_q;
    take_out   = so_ev.rise && out_rdy_q;
    commit_in  = si_ev.fall && in_busy_q;
    commit_out = so_ev.fall && out_busy_q;
    in_busy_n  = take_in  ? 1'b1 : (commit_in  ? 1'b0 : in_busy_q);
    out_busy_n = take_out ? 1'b1 : (commit_out ? 1'b0 : out_busy_q);
    rptr_n     = commit_out ? rptr_q + 1'b1 : rptr_q;
    count_n    = count_q;
    if (commit_in  && !commit_out) count_n = count_q + One;
    if (commit_out && !commit_in)  count_n = count_q - One;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      count_q    <= '0;
      in_busy_q  <= 1'b0;
      out_busy_q <= 1'b0;
      in_rdy_q   <= 1'b1;
      out_rdy_q  <= 1'b0;
    end else begin
      if (commit_in) wptr_q <= wptr_q + 1'b1;
      rptr_q     <= rptr_n;
      count_q    <= count_n;
      in_busy_q  <= in_busy_n;
      out_busy_q <= out_busy_n;
      in_rdy_q   <= !in_busy_n && (count_n < FullCnt);
      out_rdy_q  <= !out_busy_n && (count_n != '0);
    end
  end

  sfifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk  (clk),
    .rst  (rst),
    .we   (take_in),
    .waddr(wptr_q),
    .wdata(din),
    .re   (count_n != '0),
    .raddr(rptr_n),
    .rdata(dout)
  );

  sfifo_flags #(
    .DEPTH   (DEPTH),
    .LOW_MAX (EDGE_GAP),
    .HIGH_MIN(DEPTH - EDGE_GAP),
    .HALF_MIN(DEPTH / 2)
  ) u_flags (
    .clk      (clk),
    .rst      (rst),
    .count_n  (count_n),
    .flag_edge(flag_edge),
    .flag_half(flag_half)
  );

  assign in_rdy  = in_rdy_q;
  assign out_rdy = out_rdy_q;
endmodule

// File: rtl/sfifo_checker.sv
module sfifo_checker #(
  parameter int WIDTH    = 9,
  parameter int DEPTH    = 64,
  parameter int EDGE_GAP = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             shift_in,
  input logic             shift_out,
  input logic             in_rdy,
  input logic             out_rdy,
  input logic [WIDTH-1:0] dout,
  input logic             flag_edge,
  input logic             flag_half,
  input logic [CW-1:0]    count_q
);
  localparam logic [CW-1:0] FullCnt = CW'(DEPTH);
  localparam logic [CW-1:0] LoLim   = CW'(EDGE_GAP);
  localparam logic [CW-1:0] HiLim   = CW'(DEPTH - EDGE_GAP);
  localparam logic [CW-1:0] HalfLim = CW'(DEPTH / 2);

  // R1
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (in_rdy && !out_rdy && dout == '0 && flag_edge && !flag_half));

  p_in_drop_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(shift_in) && in_rdy) |=> !in_rdy);

  p_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (count_q == FullCnt) |-> !in_rdy);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    count_q <= FullCnt);

  p_empty_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (count_q == '0) |-> !out_rdy);

  p_out_drop_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(shift_out) && out_rdy) |=> !out_rdy);

  p_edge_zone_r9: assert property (@(posedge clk) disable iff (rst)
    flag_edge == ((count_q <= LoLim) || (count_q >= HiLim)));

  p_half_r10: assert property (@(posedge clk) disable iff (rst)
    flag_half == (count_q >= HalfLim));

  p_flag_timing_r11: assert property (@(posedge clk) disable iff (rst)
    (!$fell(shift_in) && !$fell(shift_out)) |=> ($stable(flag_edge) && $stable(flag_half)));
endmodule

bind strobe_fifo sfifo_checker #(
  .WIDTH(WIDTH), .DEPTH(DEPTH), .EDGE_GAP(EDGE_GAP)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .shift_in (shift_in),
  .shift_out(shift_out),
  .in_rdy   (in_rdy),
  .out_rdy  (out_rdy),
  .dout     (dout),
  .flag_edge(flag_edge),
  .flag_half(flag_half),
  .count_q  (count_q)
);

// File: tb/tb_strobe_fifo.sv
module tb_strobe_fifo;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       shift_in = 1'b0;
  logic       shift_out = 1'b0;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic       in_rdy, out_rdy, flag_edge, flag_half;

  int checks = 0;
  int errors = 0;
  int cnt = 0;
  bit done = 0;
  logic [8:0] sb [$];

  always #2 clk = ~clk;

  strobe_fifo dut (
    .clk(clk), .rst(rst), .shift_in(shift_in), .din(din), .in_rdy(in_rdy),
    .shift_out(shift_out), .dout(dout), .out_rdy(out_rdy),
    .flag_edge(flag_edge), .flag_half(flag_half)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_flags();
    check("R9 flag_edge", {8'b0, flag_edge}, {8'b0, (cnt <= 8) || (cnt >= 56)});
    check("R10 flag_half", {8'b0, flag_half}, {8'b0, cnt >= 32});
  endtask

  // Driver: loads one word and records it in the scoreboard.
  task automatic push_word(input logic [8:0] d);
    check("R3 in_rdy before load", {8'b0, in_rdy}, 9'd1);
    din = d; shift_in = 1'b1;
    @(negedge clk);
    check("R2 in_rdy drops", {8'b0, in_rdy}, 9'd0);
    shift_in = 1'b0;
    @(negedge clk);
    sb.push_back(d);
    cnt++;
    check("R3 in_rdy recovers", {8'b0, in_rdy}, {8'b0, cnt < 64});
    check("R6 out_rdy", {8'b0, out_rdy}, 9'd1);
    check_flags();
  endtask

  // Monitor: consumes one word and compares against the scoreboard.
  task automatic pop_word();
    logic [8:0] exp;
    exp = sb.pop_front();
    check("R7 out_rdy before unload", {8'b0, out_rdy}, 9'd1);
    check("R8 order", dout, exp);
    shift_out = 1'b1;
    @(negedge clk);
    check("R7 out_rdy drops", {8'b0, out_rdy}, 9'd0);
    shift_out = 1'b0;
    @(negedge clk);
    cnt--;
    check("R7 out_rdy after fall", {8'b0, out_rdy}, {8'b0, cnt > 0});
    check_flags();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    check("R1 in_rdy", {8'b0, in_rdy}, 9'd1);
    check("R1 out_rdy", {8'b0, out_rdy}, 9'd0);
    check("R1 dout", dout, 9'd0);
    check("R1 flag_edge", {8'b0, flag_edge}, 9'd1);
    check("R1 flag_half", {8'b0, flag_half}, 9'd0);

    // R5: unload pulse while empty
    shift_out = 1'b1; @(negedge clk);
    shift_out = 1'b0; @(negedge clk);
    check("R5 out_rdy empty", {8'b0, out_rdy}, 9'd0);
    check("R5 dout empty", dout, 9'd0);
    check("R5 in_rdy empty", {8'b0, in_rdy}, 9'd1);

    push_word(9'h1A5);
    check("R6 dout oldest", dout, 9'h1A5);
    pop_word();

    // Fill to 64 words
    for (int i = 0; i < 64; i++) push_word(9'((i * 37 + 5) & 9'h1FF));
    check("R3 full", {8'b0, in_rdy}, 9'd0);
    // R4: load attempt while full
    din = 9'h0FF; shift_in = 1'b1; @(negedge clk);
    shift_in = 1'b0; @(negedge clk);
    check("R4 in_rdy stays low", {8'b0, in_rdy}, 9'd0);
    check("R4 flags unchanged", {7'b0, flag_edge, flag_half}, 9'b11);
    for (int i = 0; i < 64; i++) pop_word();
    check("R4 nothing extra", {8'b0, out_rdy}, 9'd0);

    // R12: simultaneous load and unload
    for (int i = 0; i < 5; i++) push_word(9'(9'h100 + i));
    check("R12 head before", dout, sb[0]);
    din = 9'h055; shift_in = 1'b1; shift_out = 1'b1;
    @(negedge clk);
    shift_in = 1'b0; shift_out = 1'b0;
    @(negedge clk);
    void'(sb.pop_front());
    sb.push_back(9'h055);
    check("R12 in_rdy", {8'b0, in_rdy}, 9'd1);
    check("R12 out_rdy", {8'b0, out_rdy}, 9'd1);
    check_flags();
    for (int i = 0; i < 5; i++) pop_word();
    check("R12 count kept", {8'b0, out_rdy}, 9'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule